// File: doc/BRIEF.md
# Run-Time Resizable Word FIFO

This block is a synchronous first-in first-out buffer of 32-bit words. Its physical array is fixed, but the number of words it will accept is picked on every cycle from two control inputs: a large-buffer enable and a 6-bit data frame width. With the large buffer off, the FIFO holds four words. With it on, narrow frames get the whole array, medium frames get half, and wide frames get a quarter. A serial controller uses one instance to stage words for sending and another to collect received words.

The pop side reads ahead. The oldest word is always present on the read data output, and a pop request retires it at the clock edge. An empty FIFO presents zero. Alongside empty and full, the block reports a "one slot left" flag so that a producer can slow down one word early. A flush input empties the buffer in one cycle. This is the intended step before the depth selection is changed while words are still held.

Top module: `frame_depth_fifo`

## Requirements
- R1: While reset is held and at the first cycle after it, empty is 1, full and fullNext are 0, and popData is zero.
- R2: With largeMode at 0, the usable depth is 4 words, whatever frameSize is.
- R3: With largeMode at 1 and frameSize from 0 to 8, the usable depth is 32 words.
- R4: With largeMode at 1 and frameSize from 9 to 16, the usable depth is 16 words.
- R5: With largeMode at 1 and frameSize of 17 or more, the usable depth is 8 words.
- R6: A push while occupancy is at or above the usable depth, with no pop in the same cycle, is dropped and leaves the stored words unchanged.
- R7: fullNext is 1 exactly when occupancy equals the usable depth minus one. full is 1 exactly when occupancy is at or above the usable depth. The flags empty, fullNext and full are never asserted two at a time.
- R8: A pop request on an empty FIFO changes no state, and popData reads zero while the FIFO is empty.
- R9: A flush leaves the FIFO empty at the next cycle (empty 1, full 0, fullNext 0, popData zero). It takes priority over a push or pop in the same cycle.
- R10: Words leave in the order they were accepted. popData always shows the oldest stored word, and empty is 1 exactly when occupancy is zero.
- R11: A push and a pop in the same cycle on a non-empty FIFO keep occupancy constant, and this also holds when the FIFO is full.
- R12: The flags follow a change of largeMode or frameSize in the same cycle, without a flush. Stored words keep their order across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the FIFO at the next edge |
| largeMode | input | 1 | 1 selects the frame-size-dependent depth, 0 selects 4 words |
| frameSize | input | 6 | Data frame width in bits, used when largeMode is 1 |
| pushValid | input | 1 | Push pushData at the next edge |
| pushData | input | 32 | Word to store |
| popReq | input | 1 | Retire the word shown on popData at the next edge |
| popData | output | 32 | Oldest stored word, zero when empty |
| empty | output | 1 | No words stored |
| full | output | 1 | Occupancy at or above usable depth |
| fullNext | output | 1 | Occupancy equals usable depth minus one |

## Verification
The bench builds the block with its default parameters: a 32-word array, a 4-word small depth, and frame width thresholds of 8 and 16. All four usable depths can therefore be reached, including filling the whole array. A reference queue models every cycle and checks the flags and the read word against it. Directed phases cover several cases: overfilling each depth, popping when empty, streaming at full, flushing with a push in the same cycle, and shrinking the depth below the current occupancy.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

  // Strobes passed from the control to the storage
  typedef struct packed {
    logic wrEn;     // write pushData into the entry at the write pointer
    logic zeroOut;  // present zero instead of the entry at the read pointer
  } fifoStrobe_t;

  // Which usable depth is in force
  typedef enum logic [1:0] {
    DSEL_SMALL   = 2'd0,
    DSEL_FULL    = 2'd1,
    DSEL_HALF    = 2'd2,
    DSEL_QUARTER = 2'd3
  } depthSel_t;

endpackage

// File: rtl/dfifo_depth_sel.sv
module dfifo_depth_sel
  import dfifo_pkg::*;
#(
  parameter int PHYS_DEPTH  = 32,
  parameter int SMALL_DEPTH = 4,
  parameter int FSZ_W       = 6,
  parameter int NARROW_MAX  = 8,
  parameter int MID_MAX     = 16,
  localparam int CNT_W      = $clog2(PHYS_DEPTH) + 1
) (
  input  logic             largeMode,
  input  logic [FSZ_W-1:0] frameSize,
  output depthSel_t        depthSel,
  output logic [CNT_W-1:0] depth
);

  localparam logic [FSZ_W-1:0] NARROW_LIM = FSZ_W'(NARROW_MAX);
  localparam logic [FSZ_W-1:0] MID_LIM    = FSZ_W'(MID_MAX);

  always_comb begin
    if (!largeMode)                   depthSel = DSEL_SMALL;
    else if (frameSize <= NARROW_LIM) depthSel = DSEL_FULL;
    else if (frameSize <= MID_LIM)    depthSel = DSEL_HALF;
    else                              depthSel = DSEL_QUARTER;
  end

  always_comb begin
    unique case (depthSel)
      DSEL_SMALL:   depth = CNT_W'(SMALL_DEPTH);
      DSEL_FULL:    depth = CNT_W'(PHYS_DEPTH);
      DSEL_HALF:    depth = CNT_W'(PHYS_DEPTH / 2);
      DSEL_QUARTER: depth = CNT_W'(PHYS_DEPTH / 4);
      default:      depth = CNT_W'(SMALL_DEPTH);
    endcase
  end

endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl
  import dfifo_pkg::*;
#(
  parameter int PHYS_DEPTH = 32,
  localparam int PTR_W     = $clog2(PHYS_DEPTH),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic [CNT_W-1:0] depth,
  output fifoStrobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             empty,
  output logic             full,
  output logic             fullNext
);

  logic [CNT_W-1:0] count;
  logic             popOk;
  logic             pushOk;

  // Flags are compared with the depth in force this cycle
  assign empty    = (count == '0);
  assign full     = (count >= depth);
  assign fullNext = (count == depth - CNT_W'(1));

  // A pop on empty is ignored; a push at full goes ahead only with a pop
  assign popOk  = popReq && !empty;
  assign pushOk = pushValid && (!full || popOk);

  assign strobe.wrEn    = pushOk && !flush;
  assign strobe.zeroOut = empty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (flush) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
      if (pushOk) wrPtr <= wrPtr + PTR_W'(1);
      if (popOk)  rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0) && (wrPtr == rdPtr)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !popReq && !flush) |=> $stable(count) && $stable(wrPtr)); // R6

  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popReq && !pushValid && !flush) |=> $stable(rdPtr) && $stable(count)); // R8

  AST_STREAM_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && popReq && !empty && !flush) |=> $stable(count)); // R11

  AST_PUSH_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && empty && !flush) |=> !empty); // R10

endmodule

// File: rtl/dfifo_store.sv
module dfifo_store
  import dfifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PHYS_DEPTH = 32,
  localparam int PTR_W     = $clog2(PHYS_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] rowArr [PHYS_DEPTH];

  for (genvar e = 0; e < PHYS_DEPTH; e++) begin : gEntry
    logic [DATA_W-1:0] row;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        row <= '0;
      else if (strobe.wrEn && (wrPtr == PTR_W'(e)))
        row <= wrData;
    end
    assign rowArr[e] = row;
  end

  assign rdData = strobe.zeroOut ? '0 : rowArr[rdPtr];

endmodule

// File: rtl/frame_depth_fifo.sv
module frame_depth_fifo
  import dfifo_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PHYS_DEPTH  = 32,
  parameter int SMALL_DEPTH = 4,
  parameter int FSZ_W       = 6,
  parameter int NARROW_MAX  = 8,
  parameter int MID_MAX     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              largeMode,
  input  logic [FSZ_W-1:0]  frameSize,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              empty,
  output logic              full,
  output logic              fullNext
);

  localparam int PTR_W = $clog2(PHYS_DEPTH);
  localparam int CNT_W = PTR_W + 1;

  depthSel_t        depthSel;
  logic [CNT_W-1:0] depth;
  fifoStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  dfifo_depth_sel #(
    .PHYS_DEPTH (PHYS_DEPTH),
    .SMALL_DEPTH(SMALL_DEPTH),
    .FSZ_W      (FSZ_W),
    .NARROW_MAX (NARROW_MAX),
    .MID_MAX    (MID_MAX)
  ) uDepth (
    .largeMode(largeMode),
    .frameSize(frameSize),
    .depthSel (depthSel),
    .depth    (depth)
  );

  dfifo_ctrl #(
    .PHYS_DEPTH(PHYS_DEPTH)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .pushValid(pushValid),
    .popReq   (popReq),
    .depth    (depth),
    .strobe   (strobe),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .empty    (empty),
    .full     (full),
    .fullNext (fullNext)
  );

  dfifo_store #(
    .DATA_W    (DATA_W),
    .PHYS_DEPTH(PHYS_DEPTH)
  ) uStore (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrPtr (wrPtr),
    .rdPtr (rdPtr),
    .wrData(pushData),
    .rdData(popData)
  );

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (popData == '0)); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({empty, fullNext, full})); // R7

  AST_SMALL_FULL_AT_FOUR: assert property (@(posedge clk) disable iff (!rstN)
    (!largeMode && (depthSel != DSEL_SMALL)) |-> 1'b0); // R2

endmodule

// File: tb/tb_frame_depth_fifo.sv
module tb_frame_depth_fifo;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        largeMode = 1'b0;
  logic [5:0]  frameSize = 6'd4;
  logic        pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic        popReq = 1'b0;
  logic [31:0] popData;
  logic        empty;
  logic        full;
  logic        fullNext;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [31:0] sbQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_depth_fifo dut (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .largeMode(largeMode),
    .frameSize(frameSize),
    .pushValid(pushValid),
    .pushData (pushData),
    .popReq   (popReq),
    .popData  (popData),
    .empty    (empty),
    .full     (full),
    .fullNext (fullNext)
  );

  // Usable depth from R2..R5
  function automatic int expDepth(input logic lm, input logic [5:0] fs);
    if (!lm)          return 4;
    else if (fs <= 8) return 32;
    else if (fs <= 16) return 16;
    else              return 8;
  endfunction

  function automatic string depthTag(input logic lm, input logic [5:0] fs);
    if (!lm)          return "R2";
    else if (fs <= 8) return "R3";
    else if (fs <= 16) return "R4";
    else              return "R5";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Monitor and scoreboard: sampled at the falling edge, mid-cycle
  always @(negedge clk) begin
    int d;
    int n;
    bit popOk;
    bit pushOk;
    if (rstN && !done) begin
      d = expDepth(largeMode, frameSize);
      n = sbQ.size();
      chk(empty == (n == 0), "R10", 32'(empty), 32'(n == 0));
      chk(full == (n >= d), depthTag(largeMode, frameSize), 32'(full), 32'(n >= d));
      chk(fullNext == (n == d - 1), "R7", 32'(fullNext), 32'(n == d - 1));
      if (n > 0) chk(popData == sbQ[0], "R10", popData, sbQ[0]);
      else       chk(popData == '0, "R8", popData, 32'h0);
      if (flush) begin
        sbQ.delete();
      end else begin
        popOk  = popReq && (n > 0);
        pushOk = pushValid && ((n < d) || popOk);
        if (popOk)  void'(sbQ.pop_front());
        if (pushOk) sbQ.push_back(pushData);
      end
    end
  end

  // Driver: inputs change shortly after the rising edge
  task automatic drive(input bit pu, input logic [31:0] dat, input bit po, input bit fl);
    @(posedge clk);
    #2;
    pushValid = pu;
    pushData  = dat;
    popReq    = po;
    flush     = fl;
  endtask

  task automatic idle();
    drive(1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic setMode(input logic lm, input logic [5:0] fs);
    @(posedge clk);
    #2;
    largeMode = lm;
    frameSize = fs;
  endtask

  task automatic fill(input int cnt, input logic [31:0] base);
    for (int i = 0; i < cnt; i++) drive(1'b1, base + 32'(i), 1'b0, 1'b0);
    idle();
  endtask

  task automatic drain(output int popped);
    popped = 0;
    forever begin
      @(posedge clk);
      #2;
      pushValid = 1'b0;
      flush = 1'b0;
      if (empty) begin
        popReq = 1'b0;
        break;
      end
      popReq = 1'b1;
      popped++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : stim
    int c;
    logic [15:0] lf;

    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    chk(empty == 1'b1, "R1", 32'(empty), 32'h1);
    chk(full == 1'b0 && fullNext == 1'b0, "R1", {30'h0, full, fullNext}, 32'h0);
    chk(popData == '0, "R1", popData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1", 32'(empty), 32'h1);

    // R2 / R6 small mode, overfill by one
    fill(5, 32'hA000_0000);
    @(negedge clk);
    chk(full == 1'b1, "R2", 32'(full), 32'h1);
    drain(c);
    chk(c == 4, "R6", 32'(c), 32'd4);

    // R8 pop when empty, then a push still lands correctly
    drive(1'b0, 32'h0, 1'b1, 1'b0);
    @(negedge clk);
    chk(popData == '0 && empty, "R8", popData, 32'h0);
    idle();
    drive(1'b1, 32'h0000_0055, 1'b0, 1'b0);
    idle();
    @(negedge clk);
    chk(popData == 32'h55, "R8", popData, 32'h55);
    drain(c);

    // R3 depth 32, overfill, stream at full
    setMode(1'b1, 6'd8);
    fill(33, 32'hB000_0000);
    @(negedge clk);
    chk(full == 1'b1, "R3", 32'(full), 32'h1);
    for (int i = 0; i < 3; i++) drive(1'b1, 32'hC000_0000 + 32'(i), 1'b1, 1'b0);
    idle();
    @(negedge clk);
    chk(full == 1'b1, "R11", 32'(full), 32'h1);
    drain(c);
    chk(c == 32, "R3", 32'(c), 32'd32);

    // R4 depth 16
    setMode(1'b1, 6'd9);
    fill(17, 32'hD000_0000);
    drain(c);
    chk(c == 16, "R4", 32'(c), 32'd16);
    setMode(1'b1, 6'd16);
    fill(15, 32'hD100_0000);
    @(negedge clk);
    chk(fullNext == 1'b1, "R7", 32'(fullNext), 32'h1);
    drain(c);

    // R5 depth 8
    setMode(1'b1, 6'd17);
    fill(9, 32'hE000_0000);
    drain(c);
    chk(c == 8, "R5", 32'(c), 32'd8);
    setMode(1'b1, 6'd40);
    fill(8, 32'hE100_0000);
    @(negedge clk);
    chk(full == 1'b1, "R5", 32'(full), 32'h1);
    drain(c);

    // R12 shrink depth below occupancy without flush
    setMode(1'b1, 6'd5);
    fill(6, 32'hF000_0000);
    @(negedge clk);
    chk(full == 1'b0, "R12", 32'(full), 32'h0);
    setMode(1'b0, 6'd5);
    @(negedge clk);
    chk(full == 1'b1, "R12", 32'(full), 32'h1);
    drive(1'b1, 32'hF0FF_0000, 1'b0, 1'b0);
    idle();
    setMode(1'b1, 6'd5);
    drain(c);
    chk(c == 6, "R12", 32'(c), 32'd6);

    // R9 flush wins over a same-cycle push and pop
    fill(3, 32'h1200_0000);
    drive(1'b1, 32'hDEAD_BEEF, 1'b1, 1'b1);
    idle();
    @(negedge clk);
    chk(empty && !full && !fullNext && popData == '0, "R9", popData, 32'h0);

    // Mixed traffic across modes
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 100 == 0) begin
        idle();
        setMode(lf[2], {1'b0, lf[8:4]});
      end
      drive(lf[0] | lf[3], {lf, ~lf}, lf[1], lf[7:0] == 8'h5A);
    end
    idle();
    drain(c);
    idle();
    @(negedge clk);
    chk(empty == 1'b1, "R10", 32'(empty), 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule